// File: doc/BRIEF.md
# Four-Channel PWM Timer with Dead Band, Break and Capture

A 12-bit up-counting timer that drives four pulse-width outputs. The counter runs from its autoreload value up to the all-ones value and then reloads. The period is therefore the counter range minus the reload value. Each channel compares the counter against its own active duty register. Software writes duty values into preload registers. They move into the active registers at a counter overflow, but only when a transfer request bit is armed, and the hardware disarms that bit once the transfer has happened.

Channels 0 and 1 can be paired into a complementary set with a programmable dead band, so that the two never drive high at once. An emergency stop input, with a selectable active edge, latches a break state. In the break state every output shows a software-chosen safe level and the active duty registers are wiped. A capture input, also with a selectable edge, copies the counter into a capture register and raises a flag. Reading the capture register clears the flag. The flag is also offered as an interrupt request when its enable bit is set. Software reaches the block through a simple write port and a registered read port. A single clock-enable input paces the counter.

Top module: `pwm_quad_timer`

## Requirements
- R1: The counter steps up by one on each enabled clock. From the all-ones value it loads the reload value, so a period spans 2^CNT_W minus reload clocks. The reload register is at address 1.
- R2: While `cnt_en_i` is low the counter holds its value. The value is readable at address 4.
- R3: A channel output (polarity 0, enabled) is high exactly while counter < active duty. This gives duty minus reload high clocks per period, and none when duty is at or below reload. A duty of all-ones leaves a single low count. The preload duty registers are at addresses 8 to 11.
- R4: A preload value reaches the active register only at an overflow while control bit 0 (transfer request) is set. The hardware clears bit 0 at that overflow, and writing 0 to bit 0 has no effect.
- R5: Control bits [11:8] invert each channel. Control bits [15:12] enable each channel. A disabled channel drives 0.
- R6: With control bit 1 set, channel 1 becomes the complement of channel 0. Every change of channel 0's compare result blanks both outputs for the number of clocks in the dead-band register (address 2), so each high phase shrinks by that amount and the two never overlap.
- R7: A break edge latches the break state: falling edge if control bit 2 is 1, rising edge otherwise. In that state every output equals its bit in the break-level register (address 3). Control read bit 7 shows the break state, and writing 1 to control bit 5 clears it.
- R8: The break state clears all active duty registers. After the break is cleared, the outputs stay at their idle level until a new transfer.
- R9: A capture edge copies the counter into the capture register (address 5) and sets control read bit 6: falling edge if control bit 3 is 1, rising edge otherwise. A read of address 5 clears the flag. `irq_o` is high while the flag and control bit 4 are both set.
- R10: After reset all outputs, `irq_o`, control and counter read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Counter step enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Read data, valid the clock after the strobe |
| brk_i | input | 1 | Emergency stop input |
| cap_i | input | 1 | Capture input |
| pwm_o | output | 4 | Channel outputs |
| irq_o | output | 1 | Capture interrupt request |

## Verification
The bench builds the timer with a 6-bit counter and a 4-bit dead-band field. With reload 16, a full period is only 48 clocks. That makes it cheap to let several overflows pass after each preload write, and to count high clocks over whole periods for every duty and polarity setting. It also makes the corners at duty equal to reload, duty below reload and duty at all-ones easy to reach. Freezing the counter with its enable before a capture edge makes the captured value known from a plain counter read.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] RA_RELOAD = 4'd1;
  localparam logic [ADDR_W-1:0] RA_DEAD   = 4'd2;
  localparam logic [ADDR_W-1:0] RA_BRKLVL = 4'd3;
  localparam logic [ADDR_W-1:0] RA_COUNT  = 4'd4;
  localparam logic [ADDR_W-1:0] RA_CAPT   = 4'd5;
  localparam int                RA_DUTY0  = 8;

  localparam int CB_XFER    = 0;
  localparam int CB_DTEN    = 1;
  localparam int CB_BRKFALL = 2;
  localparam int CB_CAPFALL = 3;
  localparam int CB_CAPIE   = 4;
  localparam int CB_BRKCLR  = 5;
  localparam int CB_CAPFLAG = 6;
  localparam int CB_BRKFLAG = 7;
  localparam int CB_POL     = 8;
  localparam int CB_OE      = 12;
endpackage

// File: rtl/pwmq_counter.sv
module pwmq_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = en_i && (cnt_q == CNT_MAX);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (ovf_o) cnt_q <= reload_i;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_reload_on_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> cnt_q == $past(reload_i))
    else $error("counter did not reload after wrap");

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    (en_i && !ovf_o) |=> cnt_q == $past(cnt_q) + 1'b1)
    else $error("counter did not step");

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(cnt_q))
    else $error("counter moved while disabled");
endmodule

// File: rtl/pwmq_edge_sync.sv
module pwmq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = fall_sel_i ? (prev_q && !sync_q[STAGES-1])
                             : (!prev_q && sync_q[STAGES-1]);
endmodule

// File: rtl/pwmq_deadband.sv
module pwmq_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmp_i,
  input  logic [DT_W-1:0] len_i,
  output logic            blank_o
);
  logic            prev_q;
  logic [DT_W-1:0] left_q;
  logic            chg;

  assign chg = (cmp_i != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      left_q <= '0;
    end else begin
      prev_q <= cmp_i;
      if (chg)                left_q <= (len_i == '0) ? '0 : len_i - 1'b1;
      else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
  end

  assign blank_o = (chg && (len_i != '0)) || (left_q != '0);

  assert_window_load_R6: assert property (@(posedge clk) disable iff (rst)
    (chg && len_i > 1) |=> left_q == $past(len_i) - 1'b1)
    else $error("dead band window not loaded");
endmodule

// File: rtl/pwm_quad_timer.sv
module pwm_quad_timer #(
  parameter int CNT_W       = 12,
  parameter int NUM_CH      = 4,
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cnt_en_i,
  input  logic                         wr_en_i,
  input  logic [pwmq_pkg::ADDR_W-1:0]  wr_addr_i,
  input  logic [pwmq_pkg::DATA_W-1:0]  wr_data_i,
  input  logic                         rd_en_i,
  input  logic [pwmq_pkg::ADDR_W-1:0]  rd_addr_i,
  output logic [pwmq_pkg::DATA_W-1:0]  rd_data_o,
  input  logic                         brk_i,
  input  logic                         cap_i,
  output logic [NUM_CH-1:0]            pwm_o,
  output logic                         irq_o
);
  import pwmq_pkg::*;

  logic [CNT_W-1:0]  reload_q, cap_q, cnt;
  logic [DT_W-1:0]   dead_q;
  logic [NUM_CH-1:0] brk_lvl_q, pol_q, oe_q, cmp_q, base, pwm_q;
  logic              dt_en_q, brk_fall_q, cap_fall_q, cap_ie_q;
  logic              xfer_q, brk_flag_q, cap_flag_q;
  logic              ovf, brk_edge, cap_edge, blank, wr_ctrl, act_nonzero;
  logic [CNT_W-1:0]  pre_q [NUM_CH];
  logic [CNT_W-1:0]  act_q [NUM_CH];
  logic [DATA_W-1:0] rd_next;
  logic              unused_bits;

  assign unused_bits = ^{wr_data_i, rd_addr_i};
  assign wr_ctrl     = wr_en_i && (wr_addr_i == RA_CTRL);

  pwmq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(cnt_en_i), .reload_i(reload_q),
    .cnt_o(cnt), .ovf_o(ovf));

  pwmq_edge_sync #(.STAGES(SYNC_STAGES)) u_brk (
    .clk(clk), .rst(rst), .pin_i(brk_i), .fall_sel_i(brk_fall_q), .edge_o(brk_edge));

  pwmq_edge_sync #(.STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst(rst), .pin_i(cap_i), .fall_sel_i(cap_fall_q), .edge_o(cap_edge));

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0; dead_q <= '0; brk_lvl_q <= '0; pol_q <= '0; oe_q <= '0;
      dt_en_q <= 1'b0; brk_fall_q <= 1'b0; cap_fall_q <= 1'b0; cap_ie_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        RA_CTRL: begin
          dt_en_q    <= wr_data_i[CB_DTEN];
          brk_fall_q <= wr_data_i[CB_BRKFALL];
          cap_fall_q <= wr_data_i[CB_CAPFALL];
          cap_ie_q   <= wr_data_i[CB_CAPIE];
          pol_q      <= wr_data_i[CB_POL +: NUM_CH];
          oe_q       <= wr_data_i[CB_OE +: NUM_CH];
        end
        RA_RELOAD: reload_q  <= wr_data_i[CNT_W-1:0];
        RA_DEAD:   dead_q    <= wr_data_i[DT_W-1:0];
        RA_BRKLVL: brk_lvl_q <= wr_data_i[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  // transfer request, break and capture state
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q <= 1'b0; brk_flag_q <= 1'b0; cap_flag_q <= 1'b0; cap_q <= '0;
    end else begin
      if (wr_ctrl && wr_data_i[CB_XFER]) xfer_q <= 1'b1;
      else if (ovf)                      xfer_q <= 1'b0;

      if (brk_edge)                                brk_flag_q <= 1'b1;
      else if (wr_ctrl && wr_data_i[CB_BRKCLR])    brk_flag_q <= 1'b0;

      if (cap_edge) begin
        cap_q      <= cnt;
        cap_flag_q <= 1'b1;
      end else if (rd_en_i && rd_addr_i == RA_CAPT) begin
        cap_flag_q <= 1'b0;
      end
    end
  end

  // per-channel preload, active duty and compare
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(RA_DUTY0 + i);
    always_ff @(posedge clk) begin
      if (rst) begin
        pre_q[i] <= '0;
        act_q[i] <= '0;
        cmp_q[i] <= 1'b0;
      end else begin
        if (wr_en_i && wr_addr_i == DUTY_A) pre_q[i] <= wr_data_i[CNT_W-1:0];
        if (brk_flag_q)          act_q[i] <= '0;
        else if (ovf && xfer_q)  act_q[i] <= pre_q[i];
        cmp_q[i] <= (cnt < act_q[i]);
      end
    end
  end

  pwmq_deadband #(.DT_W(DT_W)) u_dead (
    .clk(clk), .rst(rst), .cmp_i(cmp_q[0]), .len_i(dead_q), .blank_o(blank));

  always_comb begin
    base = cmp_q;
    if (dt_en_q) begin
      base[0] = cmp_q[0] && !blank;
      base[1] = !cmp_q[0] && !blank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             pwm_q <= '0;
    else if (brk_flag_q) pwm_q <= brk_lvl_q;
    else                 pwm_q <= (base ^ pol_q) & oe_q;
  end

  // read port
  always_comb begin
    rd_next = '0;
    case (rd_addr_i)
      RA_CTRL: begin
        rd_next[CB_XFER]    = xfer_q;
        rd_next[CB_DTEN]    = dt_en_q;
        rd_next[CB_BRKFALL] = brk_fall_q;
        rd_next[CB_CAPFALL] = cap_fall_q;
        rd_next[CB_CAPIE]   = cap_ie_q;
        rd_next[CB_CAPFLAG] = cap_flag_q;
        rd_next[CB_BRKFLAG] = brk_flag_q;
        rd_next[CB_POL +: NUM_CH] = pol_q;
        rd_next[CB_OE +: NUM_CH]  = oe_q;
      end
      RA_RELOAD: rd_next[CNT_W-1:0]  = reload_q;
      RA_DEAD:   rd_next[DT_W-1:0]   = dead_q;
      RA_BRKLVL: rd_next[NUM_CH-1:0] = brk_lvl_q;
      RA_COUNT:  rd_next[CNT_W-1:0]  = cnt;
      RA_CAPT:   rd_next[CNT_W-1:0]  = cap_q;
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (rd_addr_i == ADDR_W'(RA_DUTY0 + i)) rd_next[CNT_W-1:0] = pre_q[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_next;
  end

  assign pwm_o = pwm_q;
  assign irq_o = cap_flag_q && cap_ie_q;

  always_comb begin
    act_nonzero = 1'b0;
    for (int i = 0; i < NUM_CH; i++) act_nonzero = act_nonzero | (act_q[i] != '0);
  end

  assert_xfer_done_R4: assert property (@(posedge clk) disable iff (rst)
    (ovf && xfer_q && !(wr_ctrl && wr_data_i[CB_XFER])) |=> !xfer_q)
    else $error("transfer request not cleared");

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    (dt_en_q && !brk_flag_q && pol_q[1:0] == 2'b00) |=> !(pwm_q[0] && pwm_q[1]))
    else $error("paired outputs overlap");

  assert_break_level_R7: assert property (@(posedge clk) disable iff (rst)
    brk_flag_q |=> pwm_q == $past(brk_lvl_q))
    else $error("break level not driven");

  assert_break_wipe_R8: assert property (@(posedge clk) disable iff (rst)
    brk_flag_q |=> !act_nonzero)
    else $error("active duty survived break");

  assert_capture_flag_R9: assert property (@(posedge clk) disable iff (rst)
    cap_edge |=> (cap_flag_q && cap_q == $past(cnt)))
    else $error("capture missed");
endmodule

// File: tb/sim_pwm_quad_timer.sv
`timescale 1ns/1ps
module sim_pwm_quad_timer;
  localparam int CNT_W = 6;
  localparam int DT_W  = 4;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int RLD   = 16;
  localparam int PER   = (1 << CNT_W) - RLD;

  logic        clk = 1'b0, rst = 1'b1, cnt_en = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, brk = 1'b0, cap = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  pwm;
  logic        irq;

  int checks = 0, failures = 0;
  int hc [4];
  int overlap, mism;
  bit sh_dt = 0, sh_bf = 0, sh_cf = 0, sh_ie = 0;
  logic [3:0] sh_pol = '0, sh_oe = '0;

  always #5 clk = ~clk;

  pwm_quad_timer #(.CNT_W(CNT_W), .NUM_CH(4), .DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .cnt_en_i(cnt_en), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .brk_i(brk), .cap_i(cap), .pwm_o(pwm), .irq_o(irq));

  function automatic int exp_high(input int d);
    return (d <= RLD) ? 0 : d - RLD;
  endfunction

  function automatic [15:0] cw(input bit xf, input bit bclr);
    return {sh_oe, sh_pol, 2'b00, bclr, sh_ie, sh_cf, sh_bf, sh_dt, xf};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input logic [3:0] lvl);
    for (int k = 0; k < 4; k++) hc[k] = 0;
    overlap = 0; mism = 0;
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) if (pwm[k]) hc[k]++;
      if (pwm[0] && pwm[1]) overlap++;
      if (pwm != lvl) mism++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v, c1, c2;
    int d, per_cnt;
    void'($urandom(32'd2024));
    waitc(5);
    @(negedge clk); rst = 1'b0;
    waitc(1);
    // R10 reset state
    check("R10 pwm", int'(pwm), 0);
    check("R10 irq", int'(irq), 0);
    rd(4'd0, v); check("R10 ctrl", int'(v), 0);
    rd(4'd4, v); check("R10 counter", int'(v), 0);

    // R2 hold while disabled
    cnt_en = 1'b1; waitc(10); cnt_en = 1'b0;
    rd(4'd4, c1); waitc(5); rd(4'd4, c2);
    check("R2 counter frozen", int'(c2), int'(c1));

    wr(4'd1, 16'(RLD));
    wr(4'd2, 16'd3);
    wr(4'd3, 16'b1010);
    wr(4'd8, 16'd44); wr(4'd9, 16'd30); wr(4'd10, 16'(RLD)); wr(4'd11, 16'(MAXV));
    sh_oe = 4'hF;
    wr(4'd0, cw(1, 0));
    cnt_en = 1'b1;
    waitc(2 * PER + 70);
    rd(4'd0, v); check("R4 transfer bit cleared", int'(v[0]), 0);
    measure(4'h0);
    check("R3 ch0 high", hc[0], 28);
    check("R3 ch1 high", hc[1], 14);
    check("R3 ch2 duty=reload", hc[2], 0);
    check("R3 ch3 duty=max", hc[3], PER - 1);

    // R1 period between rising edges
    @(negedge clk); while (!(pwm[0] == 1'b0)) @(negedge clk);
    while (pwm[0] == 1'b0) @(negedge clk);
    per_cnt = 0;
    do begin @(negedge clk); per_cnt++; end while (!(pwm[0] == 1'b1 && per_cnt > 28));
    check("R1 period", per_cnt, PER);

    // R4 no transfer without request
    wr(4'd8, 16'd20);
    waitc(2 * PER + 5); measure(4'h0);
    check("R4 held without request", hc[0], 28);
    wr(4'd0, cw(0, 0));
    waitc(2 * PER + 5); measure(4'h0);
    check("R4 write zero no request", hc[0], 28);
    wr(4'd0, cw(1, 0));
    waitc(2 * PER + 5); measure(4'h0);
    check("R4 moved on request", hc[0], 4);
    wr(4'd8, 16'd44); wr(4'd0, cw(1, 0)); waitc(2 * PER + 5);

    // R3 random duties plus a below-reload corner
    for (int it = 0; it < 7; it++) begin
      d = (it == 6) ? 5 : RLD + int'($urandom_range(0, MAXV - RLD));
      wr(4'd10, 16'(d)); wr(4'd0, cw(1, 0));
      waitc(2 * PER + 5); measure(4'h0);
      check("R3 random duty", hc[2], exp_high(d));
    end

    // R5 polarity and enable
    sh_pol = 4'b0001; wr(4'd0, cw(0, 0)); waitc(5); measure(4'h0);
    check("R5 inverted ch0", hc[0], PER - 28);
    sh_pol = 4'b0000; sh_oe = 4'b1110; wr(4'd0, cw(0, 0)); waitc(5); measure(4'h0);
    check("R5 disabled ch0", hc[0], 0);
    check("R5 ch3 still on", hc[3], PER - 1);
    sh_oe = 4'hF;

    // R6 dead band pairing
    sh_dt = 1; wr(4'd0, cw(0, 0)); waitc(PER + 5); measure(4'h0);
    check("R6 ch0 shortened", hc[0], 28 - 3);
    check("R6 ch1 complement shortened", hc[1], PER - 28 - 3);
    check("R6 no overlap", overlap, 0);
    sh_dt = 0; wr(4'd0, cw(0, 0));

    // R7 break, falling edge selected
    sh_bf = 1; wr(4'd0, cw(0, 0));
    brk = 1'b1; waitc(8);
    rd(4'd0, v); check("R7 rising ignored", int'(v[7]), 0);
    measure(4'h0); check("R7 outputs live", hc[0], 28);
    brk = 1'b0; waitc(8);
    rd(4'd0, v); check("R7 falling latched", int'(v[7]), 1);
    measure(4'b1010); check("R7 break level", mism, 0);
    // R8 wiped duties after clear
    wr(4'd0, cw(0, 1)); waitc(PER + 5);
    rd(4'd0, v); check("R7 cleared", int'(v[7]), 0);
    measure(4'h0); check("R8 idle after break", mism, 0);
    wr(4'd0, cw(1, 0)); waitc(2 * PER + 5); measure(4'h0);
    check("R8 restored by transfer", hc[0], 28);
    // R7 rising edge selected
    sh_bf = 0; wr(4'd0, cw(0, 0));
    brk = 1'b1; waitc(8);
    rd(4'd0, v); check("R7 rising latched", int'(v[7]), 1);
    wr(4'd0, cw(0, 1)); brk = 1'b0;

    // R9 capture
    sh_ie = 1; wr(4'd0, cw(0, 0));
    cnt_en = 1'b0; waitc(3);
    rd(4'd4, c1);
    check("R1 counter in range", int'(c1 >= RLD && c1 <= MAXV), 1);
    cap = 1'b1; waitc(6);
    check("R9 irq raised", int'(irq), 1);
    rd(4'd0, v); check("R9 flag set", int'(v[6]), 1);
    rd(4'd5, v); check("R9 captured value", int'(v), int'(c1));
    check("R9 irq cleared by read", int'(irq), 0);
    rd(4'd0, v); check("R9 flag cleared", int'(v[6]), 0);
    sh_cf = 1; wr(4'd0, cw(0, 0));
    cnt_en = 1'b1; waitc(7); cnt_en = 1'b0;
    rd(4'd4, c2);
    cap = 1'b0; waitc(6);
    rd(4'd5, v); check("R9 falling capture", int'(v), int'(c2));
    cap = 1'b1; waitc(6);
    rd(4'd0, v); check("R9 rising ignored", int'(v[6]), 0);
    sh_ie = 0; wr(4'd0, cw(0, 0));
    cap = 1'b0; waitc(6);
    check("R9 irq masked", int'(irq), 0);
    rd(4'd0, v); check("R9 flag with mask", int'(v[6]), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule